// File: doc/BRIEF.md
# SDLC Frame Transmitter

This block turns one host-supplied frame into a serial SDLC bit stream. A frame on the line is made of several parts, in this order. First comes an optional two-byte pre-frame sync pattern, then the opening flag, then the address byte. An optional control byte follows, taken from a side input. Next come the information bytes, then an optional 16-bit frame check sequence, and finally the closing flag. Between the flags a zero is stuffed after every run of five ones. The stuffed bit stream then passes through a line coder that gives either plain NRZ or NRZI. One bit leaves per clock in which the bit-rate strobe `bit_en` is high.

The host presents the address and the information bytes on a byte-wide valid/ready stream. `s_last` marks the final byte. The control byte and the four mode bits are inputs that the block samples once, in the clock in which a frame starts. The controlling FSM has eight states: `ST_IDLE`, `ST_PRESYNC`, `ST_OPEN`, `ST_ADDR`, `ST_CTRL`, `ST_INFO`, `ST_FCS` and `ST_CLOSE`.

The transitions are as follows. `ST_IDLE` moves to `ST_PRESYNC` (sync mode on) or to `ST_OPEN` (sync mode off) when `s_valid` is high. `ST_PRESYNC` moves to `ST_OPEN` after its second byte. `ST_OPEN` moves to `ST_ADDR`. `ST_ADDR` moves to `ST_CTRL` if a control byte is sent. Otherwise it moves to `ST_INFO`, or to the frame end if the address was the last stream byte. `ST_CTRL` moves to `ST_INFO`, or to the frame end. `ST_INFO` stays in `ST_INFO` until the byte marked last is done, then moves to the frame end. The frame end is `ST_FCS`, or `ST_CLOSE` when the check sequence is turned off. `ST_FCS` moves to `ST_CLOSE` after two bytes. `ST_CLOSE` returns to `ST_IDLE` and pulses `done`.

Top module: `sdlc_frame_tx`

## Requirements
- R1: After reset `line_out` is 1 and `busy`, `s_ready` and `done` are 0. While idle, each strobe sends a 1 bit: in NRZ the line is high, and in NRZI it keeps its level.
- R2: When idle and `s_valid` is high, `busy` rises at the next clock. In that same clock the mode inputs and `ctrl_in` are latched. No stream byte is taken in that clock.
- R3: Both the opening and the closing flag are 0x7E, sent least significant bit first and never bit-stuffed. Every byte goes out least significant bit first.
- R4: With `mode_presync` set, two sync bytes precede the opening flag, unstuffed. Each is 0x00 when `mode_nrzi` is set and 0x55 otherwise.
- R5: Field order is address (first stream byte), then `ctrl_in`, then the remaining stream bytes as information. With `mode_no_ctrl` set, no control byte is sent.
- R6: Unless `mode_no_fcs` is set, a check sequence follows the data. It uses CRC-16 (x^16+x^12+x^5+1), preset to 0xFFFF, over address, control and information. It is sent inverted, low byte first, LSB first. For the bytes of ASCII "123456789" the sent 16-bit value is 0x906E.
- R7: From the first address bit up to the closing flag, a 0 is inserted after every five consecutive 1s. This includes a run that ends at the last check sequence bit.
- R8: In NRZI mode the coder works on the stuffed stream. A 0 toggles `line_out` and a 1 holds it. In NRZ mode `line_out` equals the bit.
- R9: `line_out` changes only in the clock after a cycle with `bit_en` high, and at most one bit is sent per strobe.
- R10: Changes to the mode inputs or `ctrl_in` during a frame have no effect on that frame.
- R11: `done` is high for exactly one clock. It is high in the clock in which `line_out` first shows the last closing flag bit, and `busy` falls in that same clock.
- R12: If no stream byte is offered when the address or an information byte is due, `s_ready` stays high. While it waits, `line_out` holds and strobes are not used; the frame then resumes with nothing lost.
- R13: `s_ready` is high only during a frame. Each frame takes exactly the stream bytes up to and including the one marked `s_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate strobe, one line bit per high cycle |
| mode_nrzi | input | 1 | 1 selects NRZI coding, 0 NRZ |
| mode_presync | input | 1 | 1 sends the two-byte sync pattern |
| mode_no_ctrl | input | 1 | 1 omits the control byte |
| mode_no_fcs | input | 1 | 1 omits the check sequence |
| ctrl_in | input | 8 | Control byte, latched at frame start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte (address, then information) |
| s_last | input | 1 | Marks the final stream byte of a frame |
| s_ready | output | 1 | Block takes the stream byte this clock |
| line_out | output | 1 | Coded serial line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the closing flag's last bit |

## Verification
The bench sweeps all sixteen mode combinations over payloads made of 0xFF bytes, bytes that look like flags, and single-byte frames. It rebuilds each expected bit stream arithmetically and decodes NRZI back to bits. A stuffer that missed the run ending at the last check sequence bit would corrupt the closing flag. A preamble that did not follow the coding choice would break the sync-byte bits. A CRC that was wrongly preset or bit-ordered would break the known-answer frame.

A frame stalled before its address checks that the line holds and no strobe is used up. A frame whose mode inputs are flipped after the start checks that the latched copy alone steers the frame. Every frame also checks that `done` lands exactly on the final flag bit, and that every offered byte was taken.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRESYNC,
        ST_OPEN,
        ST_ADDR,
        ST_CTRL,
        ST_INFO,
        ST_FCS,
        ST_CLOSE
    } tx_state_t;

    typedef struct packed {
        logic nrzi;
        logic presync;
        logic no_ctrl;
        logic no_fcs;
    } tx_mode_t;

endpackage

// File: rtl/sdlc_tx_crc16.sv
// Bit-serial reflected CRC; crc_nx is the value after absorbing din.
module sdlc_tx_crc16 #(
    parameter int              CRC_W    = 16,
    parameter logic [CRC_W-1:0] POLY_REF = 16'h8408,
    parameter logic [CRC_W-1:0] INIT     = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             din,
    output logic [CRC_W-1:0] crc_nx
);
    logic [CRC_W-1:0] crc_q;
    logic             fb;

    always_comb begin
        fb     = crc_q[0] ^ din;
        crc_nx = fb ? ((crc_q >> 1) ^ POLY_REF) : (crc_q >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_q <= INIT;
        end else if (shift) begin
            crc_q <= crc_nx;
        end
    end
endmodule

// File: rtl/sdlc_tx_line_coder.sv
// Line register: NRZ copies the bit, NRZI toggles on a zero.
module sdlc_tx_line_coder (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_in,
    input  logic nrzi,
    output logic line_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else if (tick) begin
            if (nrzi) begin
                line_q <= bit_in ? line_q : ~line_q;
            end else begin
                line_q <= bit_in;
            end
        end
    end
endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx
    import sdlc_tx_pkg::*;
#(
    parameter logic [7:0]  FLAG_BYTE = 8'h7E,
    parameter logic [7:0]  SYNC_NRZ  = 8'h55,
    parameter logic [7:0]  SYNC_NRZI = 8'h00,
    parameter int          SYNC_BYTES = 2,
    parameter int          STUFF_RUN = 5,
    parameter logic [15:0] CRC_POLY  = 16'h8408,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       mode_nrzi,
    input  logic       mode_presync,
    input  logic       mode_no_ctrl,
    input  logic       mode_no_fcs,
    input  logic [7:0] ctrl_in,
    input  logic       s_valid,
    input  logic [7:0] s_data,
    input  logic       s_last,
    output logic       s_ready,
    output logic       line_out,
    output logic       busy,
    output logic       done
);
    localparam int BYTE_W    = 8;
    localparam int BCNT_W    = $clog2(BYTE_W);
    localparam int FCS_BYTES = 2;
    localparam int IDX_W     = $clog2(SYNC_BYTES + FCS_BYTES);
    localparam int ONES_W    = $clog2(STUFF_RUN + 1);
    localparam int CRC_W     = 16;

    tx_state_t          state_q, nxt_state;
    tx_mode_t           mode_q;
    logic [BYTE_W-1:0]  ctrl_q;
    logic [BYTE_W-1:0]  sh_q;
    logic [BCNT_W-1:0]  bcnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [ONES_W-1:0]  ones_q;
    logic [BYTE_W-1:0]  fcs_hi_q;
    logic               have_q;
    logic               fin_q;
    logic               done_q;

    logic               emit, insert, data_bit_tx, byte_end;
    logic               stuff_state, crc_state;
    logic               ld_const, want_stream, take, fcs_latch, go_end, done_set;
    logic [BYTE_W-1:0]  ld_val;
    logic               tx_bit, coder_tick;
    logic [CRC_W-1:0]   crc_nx;

    function automatic logic [BYTE_W-1:0] sync_byte(input logic nrzi_sel);
        return nrzi_sel ? SYNC_NRZI : SYNC_NRZ;
    endfunction

    // ---------------- bit timing ----------------
    always_comb begin
        stuff_state = (state_q == ST_ADDR) || (state_q == ST_CTRL) ||
                      (state_q == ST_INFO) || (state_q == ST_FCS);
        crc_state   = (state_q == ST_ADDR) || (state_q == ST_CTRL) ||
                      (state_q == ST_INFO);
        emit        = bit_en && have_q && (state_q != ST_IDLE);
        insert      = emit && (ones_q == ONES_W'(STUFF_RUN));
        data_bit_tx = emit && !insert;
        byte_end    = data_bit_tx && (bcnt_q == BCNT_W'(BYTE_W - 1));
        tx_bit      = (state_q == ST_IDLE) ? 1'b1 : (insert ? 1'b0 : sh_q[0]);
        coder_tick  = bit_en && ((state_q == ST_IDLE) || have_q);
    end

    // ---------------- next state and byte source ----------------
    always_comb begin
        nxt_state   = state_q;
        ld_const    = 1'b0;
        ld_val      = FLAG_BYTE;
        want_stream = 1'b0;
        fcs_latch   = 1'b0;
        go_end      = 1'b0;
        done_set    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid) begin
                    ld_const  = 1'b1;
                    nxt_state = mode_presync ? ST_PRESYNC : ST_OPEN;
                    ld_val    = mode_presync ? sync_byte(mode_nrzi) : FLAG_BYTE;
                end
            end
            ST_PRESYNC: begin
                if (byte_end) begin
                    ld_const = 1'b1;
                    if (idx_q == IDX_W'(SYNC_BYTES - 1)) begin
                        nxt_state = ST_OPEN;
                        ld_val    = FLAG_BYTE;
                    end else begin
                        ld_val = sync_byte(mode_q.nrzi);
                    end
                end
            end
            ST_OPEN: begin
                if (byte_end) begin
                    nxt_state   = ST_ADDR;
                    want_stream = 1'b1;
                end
            end
            ST_ADDR: begin
                if (!have_q) begin
                    want_stream = 1'b1;
                end else if (byte_end) begin
                    if (!mode_q.no_ctrl) begin
                        nxt_state = ST_CTRL;
                        ld_const  = 1'b1;
                        ld_val    = ctrl_q;
                    end else if (fin_q) begin
                        go_end = 1'b1;
                    end else begin
                        nxt_state   = ST_INFO;
                        want_stream = 1'b1;
                    end
                end
            end
            ST_CTRL: begin
                if (byte_end) begin
                    if (fin_q) begin
                        go_end = 1'b1;
                    end else begin
                        nxt_state   = ST_INFO;
                        want_stream = 1'b1;
                    end
                end
            end
            ST_INFO: begin
                if (!have_q) begin
                    want_stream = 1'b1;
                end else if (byte_end) begin
                    if (fin_q) begin
                        go_end = 1'b1;
                    end else begin
                        want_stream = 1'b1;
                    end
                end
            end
            ST_FCS: begin
                if (byte_end) begin
                    ld_const = 1'b1;
                    if (idx_q == IDX_W'(FCS_BYTES - 1)) begin
                        nxt_state = ST_CLOSE;
                        ld_val    = FLAG_BYTE;
                    end else begin
                        ld_val = fcs_hi_q;
                    end
                end
            end
            ST_CLOSE: begin
                if (byte_end) begin
                    nxt_state = ST_IDLE;
                    done_set  = 1'b1;
                end
            end
        endcase
        if (go_end) begin
            ld_const = 1'b1;
            if (mode_q.no_fcs) begin
                nxt_state = ST_CLOSE;
                ld_val    = FLAG_BYTE;
            end else begin
                nxt_state = ST_FCS;
                ld_val    = ~crc_nx[7:0];
                fcs_latch = 1'b1;
            end
        end
        take = want_stream && s_valid;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt_state;
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            ctrl_q   <= '0;
            sh_q     <= '0;
            bcnt_q   <= '0;
            idx_q    <= '0;
            ones_q   <= '0;
            fcs_hi_q <= '0;
            have_q   <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && s_valid) begin
                mode_q <= '{nrzi: mode_nrzi, presync: mode_presync,
                            no_ctrl: mode_no_ctrl, no_fcs: mode_no_fcs};
                ctrl_q <= ctrl_in;
            end
            if (take) begin
                sh_q   <= s_data;
                bcnt_q <= '0;
                have_q <= 1'b1;
                fin_q  <= s_last;
            end else if (ld_const) begin
                sh_q   <= ld_val;
                bcnt_q <= '0;
                have_q <= 1'b1;
            end else if (byte_end) begin
                have_q <= 1'b0;
            end else if (data_bit_tx) begin
                sh_q   <= sh_q >> 1;
                bcnt_q <= bcnt_q + 1'b1;
            end
            if (fcs_latch) begin
                fcs_hi_q <= ~crc_nx[15:8];
            end
            if (insert) begin
                ones_q <= '0;
            end else if (data_bit_tx) begin
                ones_q <= (stuff_state && sh_q[0]) ? ones_q + 1'b1 : '0;
            end
            if (nxt_state != state_q) begin
                idx_q <= '0;
            end else if (byte_end) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= done_set;
        end
    end

    assign s_ready = want_stream;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;

    sdlc_tx_crc16 #(
        .CRC_W    (CRC_W),
        .POLY_REF (CRC_POLY),
        .INIT     (CRC_INIT)
    ) i_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (state_q == ST_IDLE),
        .shift  (data_bit_tx && crc_state),
        .din    (sh_q[0]),
        .crc_nx (crc_nx)
    );

    sdlc_tx_line_coder i_coder (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (coder_tick),
        .bit_in (tx_bit),
        .nrzi   (mode_q.nrzi),
        .line_q (line_out)
    );
endmodule

// File: rtl/sdlc_frame_tx_chk.sv
module sdlc_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       s_valid,
    input logic       s_ready,
    input logic       line_out,
    input logic       busy,
    input logic       done,
    input logic [3:0] mode_q
);
    // R9
    line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_out));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R13
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> busy);

    // R2
    start_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(s_valid));

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mode_q));
endmodule

bind sdlc_frame_tx sdlc_frame_tx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .line_out (line_out),
    .busy     (busy),
    .done     (done),
    .mode_q   (mode_q)
);

// File: tb/test_sdlc_frame_tx.sv
`timescale 1ns/1ps
module test_sdlc_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       mode_nrzi = 1'b0, mode_presync = 1'b0, mode_no_ctrl = 1'b0, mode_no_fcs = 1'b0;
    logic [7:0] ctrl_in = 8'h00;
    logic       s_valid, s_last, s_ready, line_out, busy, done;
    logic [7:0] s_data;

    logic [7:0] q [0:1023];
    int         qi, qn;
    logic       hold = 1'b0;

    int checks = 0, failures = 0, cyc = 0;
    logic [7:0] pay [0:15];
    logic       exp_bits [0:2047];
    int         en, ones;
    logic       last_raw;
    int         r9bad;

    always #10 clk = ~clk;

    assign s_valid = (qi < qn) && !hold;
    assign s_data  = q[qi[9:0]];
    assign s_last  = (qi == qn - 1);

    always @(posedge clk) begin
        if (!rst_n) qi <= 0;
        else if (s_valid && s_ready) qi <= qi + 1;
    end

    sdlc_frame_tx i_sdlc_frame_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .mode_nrzi(mode_nrzi), .mode_presync(mode_presync),
        .mode_no_ctrl(mode_no_ctrl), .mode_no_fcs(mode_no_fcs),
        .ctrl_in(ctrl_in), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .line_out(line_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int k = 0; k < 8; k++) begin
            if (r[0] ^ b[k]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic push_raw(input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            exp_bits[en] = b[k];
            en++;
        end
    endtask

    task automatic push_stuff(input logic [7:0] b);
        for (int k = 0; k < 8; k++) begin
            exp_bits[en] = b[k];
            en++;
            if (b[k]) begin
                ones++;
                if (ones == 5) begin
                    exp_bits[en] = 1'b0;
                    en++;
                    ones = 0;
                end
            end else begin
                ones = 0;
            end
        end
    endtask

    // m = {nrzi, presync, no_ctrl, no_fcs}
    task automatic build(input logic [3:0] m, input logic [7:0] ctl, input int n);
        logic [15:0] c;
        en = 0;
        ones = 0;
        if (m[2]) begin
            push_raw(m[3] ? 8'h00 : 8'h55);
            push_raw(m[3] ? 8'h00 : 8'h55);
        end
        push_raw(8'h7E);
        c = 16'hFFFF;
        push_stuff(pay[0]);
        c = crc_byte(c, pay[0]);
        if (!m[1]) begin
            push_stuff(ctl);
            c = crc_byte(c, ctl);
        end
        for (int k = 1; k < n; k++) begin
            push_stuff(pay[k]);
            c = crc_byte(c, pay[k]);
        end
        if (!m[0]) begin
            c = ~c;
            push_stuff(c[7:0]);
            push_stuff(c[15:8]);
        end
        push_raw(8'h7E);
    endtask

    task automatic slot();
        @(negedge clk);
        if (line_out !== last_raw) r9bad++;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        last_raw = line_out;
    endtask

    task automatic run_frame(input logic [3:0] m, input logic [7:0] ctl, input int n,
                             input bit swap, input bit stall);
        string req;
        logic  prev, d;
        int    firstbad, bad_act, bad_exp, donebad, stall_pt, qi_hold;
        req = "R3 R5 R7";
        if (m[3]) req = {req, " R8"};
        if (m[2]) req = {req, " R4"};
        if (!m[0]) req = {req, " R6"};
        if (swap) req = {req, " R10"};
        if (stall) req = {req, " R12"};
        @(negedge clk);
        {mode_nrzi, mode_presync, mode_no_ctrl, mode_no_fcs} = m;
        ctrl_in = ctl;
        for (int k = 0; k < n; k++) q[qn + k] = pay[k];
        qn = qn + n;
        build(m, ctl, n);
        @(negedge clk);
        check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        check(s_ready === 1'b0, "R2", "no take at start", int'(s_ready), 0);
        if (swap) begin
            {mode_nrzi, mode_presync, mode_no_ctrl, mode_no_fcs} = ~m;
            ctrl_in = ~ctl;
        end
        if (stall) hold = 1'b1;
        prev = line_out;
        last_raw = line_out;
        r9bad = 0;
        firstbad = -1; bad_act = 0; bad_exp = 0; donebad = 0;
        stall_pt = m[2] ? 24 : 8;
        for (int i = 0; i < en; i++) begin
            if (stall && i == stall_pt) begin
                check(s_ready === 1'b1, "R12", "ready while waiting", int'(s_ready), 1);
                qi_hold = qi;
                for (int s = 0; s < 4; s++) slot();
                check(line_out === prev, "R12", "line held in stall", int'(line_out), int'(prev));
                check(qi == qi_hold, "R12", "no byte taken in stall", qi, qi_hold);
                @(negedge clk);
                hold = 1'b0;
            end
            slot();
            d = m[3] ? (line_out == prev) : line_out;
            prev = line_out;
            if (d !== exp_bits[i] && firstbad < 0) begin
                firstbad = i; bad_act = int'(d); bad_exp = int'(exp_bits[i]);
            end
            if (done !== (i == en - 1)) donebad++;
        end
        check(firstbad < 0, req, $sformatf("bit stream, first bad bit %0d", firstbad), bad_act, bad_exp);
        check(donebad == 0, "R11", "done only on last bit", donebad, 0);
        check(busy === 1'b0, "R11", "busy low at done", int'(busy), 0);
        check(r9bad == 0, "R9", "line moved without strobe", r9bad, 0);
        check(qi == qn, "R13", "all stream bytes taken", qi, qn);
        for (int s = 0; s < 2; s++) begin
            slot();
            d = m[3] ? (line_out == prev) : line_out;
            prev = line_out;
            check(d === 1'b1, "R1", "idle marking bit", int'(d), 1);
        end
        if (!m[3]) check(line_out === 1'b1, "R1", "NRZ idle level", int'(line_out), 1);
    endtask

    initial begin
        logic [15:0] kc;
        qn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out === 1'b1, "R1", "reset line", int'(line_out), 1);
        check(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
        check(s_ready === 1'b0, "R1", "reset ready", int'(s_ready), 0);
        check(done === 1'b0, "R1", "reset done", int'(done), 0);

        // R6 known answer on the bench model
        kc = 16'hFFFF;
        for (int k = 0; k < 9; k++) kc = crc_byte(kc, 8'h31 + 8'(k));
        check(~kc == 16'h906E, "R6", "CRC known answer", int'(~kc), 16'h906E);

        // R6 known-answer frame: '1' address, '2' control, "3456789" info
        pay[0] = 8'h31;
        for (int k = 1; k < 8; k++) pay[k] = 8'h32 + 8'(k);
        run_frame(4'b0000, 8'h32, 8, 1'b0, 1'b0);

        // full sweep of mode combinations over three payloads
        for (int m = 0; m < 16; m++) begin
            for (int p = 0; p < 3; p++) begin
                if (p == 0) begin
                    pay[0] = 8'h03;
                    run_frame(4'(m), 8'h13, 1, 1'b0, 1'b0);
                end else if (p == 1) begin
                    pay[0] = 8'hFF; pay[1] = 8'h7E; pay[2] = 8'h3F;
                    run_frame(4'(m), 8'hFF, 3, 1'b0, 1'b0);
                end else begin
                    pay[0] = 8'hA5; pay[1] = 8'hFF; pay[2] = 8'hFF; pay[3] = 8'h00;
                    run_frame(4'(m), 8'hF8, 4, 1'b0, 1'b0);
                end
            end
        end

        // R10 mode inputs flipped mid-frame
        pay[0] = 8'hC3; pay[1] = 8'h1F; pay[2] = 8'hF0;
        run_frame(4'b0000, 8'h5A, 3, 1'b1, 1'b0);
        run_frame(4'b1100, 8'h0F, 3, 1'b1, 1'b0);

        // R12 host late with the address byte
        pay[0] = 8'hFF; pay[1] = 8'h81;
        run_frame(4'b0001, 8'h7C, 2, 1'b0, 1'b1);
        run_frame(4'b1100, 8'h7C, 2, 1'b0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule